// File: doc/BRIEF.md
# Asynchronous External Bus Cycle Sequencer

This block runs one chip-select access on an external asynchronous memory or peripheral bus. When it is idle, a request is taken together with its direction, address, write data and a set of tick positions. The positions give, counted from the first tick of the access, where each active-low strobe (chip select, address valid, output enable, write enable) goes low and where it goes high again. They also give the tick at which read data is first valid and the total length of the access. All of these values are latched when the request is taken, so the caller may change its inputs while the access runs.

The sequencer has two bus arrangements. With a separate address bus, the address is held on its own output for the whole access. A write then drives its data on the data bus from the first tick to the last, and a read leaves the data bus released. With a shared address/data bus, the address is driven on the shared lines until address valid is due to go high. After that the lines are released, or, on a write, taken over by the write data from a programmed tick until the end of the access. Read data is captured from the bus on the programmed access tick. A one-tick done pulse marks the last tick of every access.

Top module: `ext_bus_seq`

## Requirements
- R1: After an asynchronous reset, or while `rst_ni` is low, all four strobes are high. `busy_o`, `done_o` and `ad_oe_o` are low, and `rdata_o` and `addr_o` are zero.
- R2: A request taken while idle starts an access on the next clock, with `busy_o` high for exactly N ticks. N is `wr_len_i` for a write and `rd_len_i` for a read, and a length of 0 counts as 1. `done_o` is high only on the final tick (tick N-1). All tick values are sampled when the request is taken.
- R3: A request presented while `busy_o` is high is ignored. It neither lengthens the running access nor changes `addr_o`, and the latched timing is not disturbed.
- R4: Tick t is the t-th clock of the access, starting at 0. A strobe is low on tick t exactly when on <= t < off. If off <= on, the strobe never goes low. Chip select uses `cs_on_i` with off = `access_i`+1 for reads and `cs_wr_off_i` for writes. Address valid uses `adv_on_i` with `adv_rd_off_i` or `adv_wr_off_i`, chosen by direction.
- R5: Output enable goes low only on reads, on ticks `oe_on_i` through `access_i`, so its high edge falls one tick after the access tick. Write enable goes low only on writes, from `we_on_i` up to, but not including, `we_off_i`. The two are never low together.
- R6: On a read, `rdata_o` takes the value of `ad_i` present during the access tick. It holds that value through the done pulse and keeps it until the next read captures. Writes and idle time leave it unchanged.
- R7: With `mux_i`=0, `addr_o` holds the request address for the whole access. A write drives `ad_o` = write data with `ad_oe_o`=1 on every tick, and a read keeps `ad_oe_o`=0.
- R8: With `mux_i`=1, on ticks below the address-valid off tick, `ad_o` carries the address with `ad_oe_o`=1. On a write, from tick `data_on_i` to the end, `ad_o` carries the write data, and the data takes precedence where the two ranges overlap. On all other ticks `ad_oe_o` is 0.
- R9: While `busy_o` is low, all strobes are high and `ad_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one tick per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start request, taken only while idle |
| wr_i | input | 1 | 1 = write access, 0 = read access |
| mux_i | input | 1 | 1 = shared address/data bus |
| addr_i | input | BW | Access address |
| wdata_i | input | BW | Write data |
| cs_on_i | input | TW | Chip select low tick |
| cs_wr_off_i | input | TW | Chip select high tick on writes |
| adv_on_i | input | TW | Address valid low tick |
| adv_rd_off_i | input | TW | Address valid high tick on reads |
| adv_wr_off_i | input | TW | Address valid high tick on writes |
| oe_on_i | input | TW | Output enable low tick |
| access_i | input | TW | Tick of first valid read data |
| we_on_i | input | TW | Write enable low tick |
| we_off_i | input | TW | Write enable high tick |
| data_on_i | input | TW | Tick at which write data replaces address on the shared bus |
| rd_len_i | input | TW | Read access length in ticks |
| wr_len_i | input | TW | Write access length in ticks |
| ad_i | input | BW | Bus input lines sampled for read data |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | Final tick of the access |
| cs_no | output | 1 | Chip select, active low |
| adv_no | output | 1 | Address valid, active low |
| oe_no | output | 1 | Output enable, active low |
| we_no | output | 1 | Write enable, active low |
| addr_o | output | BW | Latched address |
| ad_o | output | BW | Bus output lines |
| ad_oe_o | output | 1 | Bus output enable |
| rdata_o | output | BW | Captured read data |

## Verification
The bench goes after off-by-one edges. If chip select or output enable released on the access tick instead of one tick later, the per-tick trace would show them high one tick early, and a capture a tick off would return a bus value from the wrong tick. Empty windows (off at or below on) and a zero length are driven to catch a comparator that wraps or a counter that runs 2^TW ticks. The shared-bus cases include a gap between the address and data phases and one where data meets the address-valid edge, so a bus that stays enabled, or one that lets the address override the data, shows as a wrong `ad_oe_o` or `ad_o`. Every access also presents a conflicting request with a different address mid-cycle, which a missing busy lock would turn into a stretched access or a changed `addr_o`.

// File: rtl/ebs_pkg.sv
package ebs_pkg;
  localparam int NUM_STB = 4;

  typedef enum logic [1:0] {
    STB_CS  = 2'd0,
    STB_ADV = 2'd1,
    STB_OE  = 2'd2,
    STB_WE  = 2'd3
  } stb_e;

  typedef enum logic [1:0] {
    BUS_OFF  = 2'd0,
    BUS_ADDR = 2'd1,
    BUS_DATA = 2'd2
  } bus_src_e;
endpackage

// File: rtl/ebs_tick_ctr.sv
module ebs_tick_ctr #(
  parameter int TW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [TW-1:0] last_cur_i,
  input  logic [TW-1:0] last_nxt_i,
  output logic          accept_o,
  output logic          run_q_o,
  output logic [TW-1:0] tick_q_o,
  output logic          run_nxt_o,
  output logic [TW-1:0] tick_nxt_o,
  output logic          done_o
);
  logic          run_q;
  logic [TW-1:0] tick_q;
  logic          done_q;
  logic          at_last;
  logic          cont;

  always_comb begin
    at_last    = run_q && (tick_q == last_cur_i);
    cont       = run_q && !at_last;
    accept_o   = req_i && !run_q;
    run_nxt_o  = accept_o || cont;
    tick_nxt_o = cont ? tick_q + TW'(1) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      tick_q <= '0;
      done_q <= 1'b0;
    end else begin
      run_q  <= run_nxt_o;
      tick_q <= tick_nxt_o;
      done_q <= run_nxt_o && (tick_nxt_o == last_nxt_i);
    end
  end

  assign run_q_o  = run_q;
  assign tick_q_o = tick_q;
  assign done_o   = done_q;
endmodule

// File: rtl/ebs_strobe.sv
module ebs_strobe #(
  parameter int TW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_nxt_i,
  input  logic [TW-1:0] tick_nxt_i,
  input  logic [TW:0]   on_i,
  input  logic [TW:0]   off_i,
  output logic          stb_no
);
  logic [TW:0] t_ext;
  logic        act;

  always_comb begin
    t_ext = {1'b0, tick_nxt_i};
    act   = run_nxt_i && (t_ext >= on_i) && (t_ext < off_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stb_no <= 1'b1;
    else         stb_no <= !act;
  end
endmodule

// File: rtl/ebs_bus_ctl.sv
module ebs_bus_ctl
  import ebs_pkg::*;
#(
  parameter int TW = 6,
  parameter int BW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_nxt_i,
  input  logic [TW-1:0] tick_nxt_i,
  input  logic          nxt_mux_i,
  input  logic          nxt_wr_i,
  input  logic [BW-1:0] nxt_addr_i,
  input  logic [BW-1:0] nxt_wdata_i,
  input  logic [TW:0]   nxt_adv_off_i,
  input  logic [TW-1:0] nxt_data_on_i,
  input  logic          run_q_i,
  input  logic [TW-1:0] tick_q_i,
  input  logic          cur_wr_i,
  input  logic [TW-1:0] cur_access_i,
  input  logic [BW-1:0] ad_i,
  output logic [BW-1:0] ad_o,
  output logic          ad_oe_o,
  output logic [BW-1:0] rdata_o
);
  bus_src_e src;

  always_comb begin
    if (!run_nxt_i)                                   src = BUS_OFF;
    else if (!nxt_mux_i)                              src = nxt_wr_i ? BUS_DATA : BUS_OFF;
    else if (nxt_wr_i && tick_nxt_i >= nxt_data_on_i) src = BUS_DATA;
    else if ({1'b0, tick_nxt_i} < nxt_adv_off_i)      src = BUS_ADDR;
    else                                              src = BUS_OFF;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ad_o    <= '0;
      ad_oe_o <= 1'b0;
      rdata_o <= '0;
    end else begin
      ad_oe_o <= (src != BUS_OFF);
      unique case (src)
        BUS_ADDR: ad_o <= nxt_addr_i;
        BUS_DATA: ad_o <= nxt_wdata_i;
        default:  ad_o <= '0;
      endcase
      // capture at the edge closing the access tick
      if (run_q_i && !cur_wr_i && tick_q_i == cur_access_i) rdata_o <= ad_i;
    end
  end
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
  import ebs_pkg::*;
#(
  parameter int TW = 6,
  parameter int BW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          wr_i,
  input  logic          mux_i,
  input  logic [BW-1:0] addr_i,
  input  logic [BW-1:0] wdata_i,
  input  logic [TW-1:0] cs_on_i,
  input  logic [TW-1:0] cs_wr_off_i,
  input  logic [TW-1:0] adv_on_i,
  input  logic [TW-1:0] adv_rd_off_i,
  input  logic [TW-1:0] adv_wr_off_i,
  input  logic [TW-1:0] oe_on_i,
  input  logic [TW-1:0] access_i,
  input  logic [TW-1:0] we_on_i,
  input  logic [TW-1:0] we_off_i,
  input  logic [TW-1:0] data_on_i,
  input  logic [TW-1:0] rd_len_i,
  input  logic [TW-1:0] wr_len_i,
  input  logic [BW-1:0] ad_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          cs_no,
  output logic          adv_no,
  output logic          oe_no,
  output logic          we_no,
  output logic [BW-1:0] addr_o,
  output logic [BW-1:0] ad_o,
  output logic          ad_oe_o,
  output logic [BW-1:0] rdata_o
);
  localparam int TW1 = TW + 1;

  typedef struct packed {
    logic          wr;
    logic          mux;
    logic [BW-1:0] addr;
    logic [BW-1:0] wdata;
    logic [TW-1:0] cs_on;
    logic [TW-1:0] cs_wr_off;
    logic [TW-1:0] adv_on;
    logic [TW-1:0] adv_rd_off;
    logic [TW-1:0] adv_wr_off;
    logic [TW-1:0] oe_on;
    logic [TW-1:0] access;
    logic [TW-1:0] we_on;
    logic [TW-1:0] we_off;
    logic [TW-1:0] data_on;
    logic [TW-1:0] rd_len;
    logic [TW-1:0] wr_len;
  } cmd_t;

  function automatic logic [TW-1:0] last_of(input cmd_t c);
    logic [TW-1:0] len;
    len = c.wr ? c.wr_len : c.rd_len;
    return (len == '0) ? '0 : len - TW'(1);
  endfunction

  function automatic logic [TW:0] ext(input logic [TW-1:0] v);
    return {1'b0, v};
  endfunction

  cmd_t          cmd_q, cmd_nxt;
  logic          accept, run_q, run_nxt;
  logic [TW-1:0] tick_q, tick_nxt;
  logic [TW:0]   acc_end, adv_off;
  logic [TW:0]   on_v  [NUM_STB];
  logic [TW:0]   off_v [NUM_STB];
  logic          stb_n [NUM_STB];

  always_comb begin
    cmd_nxt = cmd_q;
    if (accept) begin
      cmd_nxt = '{wr: wr_i, mux: mux_i, addr: addr_i, wdata: wdata_i,
                  cs_on: cs_on_i, cs_wr_off: cs_wr_off_i, adv_on: adv_on_i,
                  adv_rd_off: adv_rd_off_i, adv_wr_off: adv_wr_off_i,
                  oe_on: oe_on_i, access: access_i, we_on: we_on_i,
                  we_off: we_off_i, data_on: data_on_i,
                  rd_len: rd_len_i, wr_len: wr_len_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cmd_q <= '0;
    else         cmd_q <= cmd_nxt;
  end

  ebs_tick_ctr #(.TW(TW)) i_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .last_cur_i (last_of(cmd_q)),
    .last_nxt_i (last_of(cmd_nxt)),
    .accept_o   (accept),
    .run_q_o    (run_q),
    .tick_q_o   (tick_q),
    .run_nxt_o  (run_nxt),
    .tick_nxt_o (tick_nxt),
    .done_o     (done_o)
  );

  // OE and read-side CS release one tick past the access tick
  always_comb begin
    acc_end = ext(cmd_nxt.access) + TW1'(1);
    adv_off = ext(cmd_nxt.wr ? cmd_nxt.adv_wr_off : cmd_nxt.adv_rd_off);
    on_v[int'(STB_CS)]   = ext(cmd_nxt.cs_on);
    off_v[int'(STB_CS)]  = cmd_nxt.wr ? ext(cmd_nxt.cs_wr_off) : acc_end;
    on_v[int'(STB_ADV)]  = ext(cmd_nxt.adv_on);
    off_v[int'(STB_ADV)] = adv_off;
    on_v[int'(STB_OE)]   = ext(cmd_nxt.oe_on);
    off_v[int'(STB_OE)]  = cmd_nxt.wr ? '0 : acc_end;
    on_v[int'(STB_WE)]   = ext(cmd_nxt.we_on);
    off_v[int'(STB_WE)]  = cmd_nxt.wr ? ext(cmd_nxt.we_off) : '0;
  end

  for (genvar g = 0; g < NUM_STB; g++) begin : g_stb
    ebs_strobe #(.TW(TW)) i_stb (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .run_nxt_i  (run_nxt),
      .tick_nxt_i (tick_nxt),
      .on_i       (on_v[g]),
      .off_i      (off_v[g]),
      .stb_no     (stb_n[g])
    );
  end

  ebs_bus_ctl #(.TW(TW), .BW(BW)) i_bus (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .run_nxt_i     (run_nxt),
    .tick_nxt_i    (tick_nxt),
    .nxt_mux_i     (cmd_nxt.mux),
    .nxt_wr_i      (cmd_nxt.wr),
    .nxt_addr_i    (cmd_nxt.addr),
    .nxt_wdata_i   (cmd_nxt.wdata),
    .nxt_adv_off_i (adv_off),
    .nxt_data_on_i (cmd_nxt.data_on),
    .run_q_i       (run_q),
    .tick_q_i      (tick_q),
    .cur_wr_i      (cmd_q.wr),
    .cur_access_i  (cmd_q.access),
    .ad_i          (ad_i),
    .ad_o          (ad_o),
    .ad_oe_o       (ad_oe_o),
    .rdata_o       (rdata_o)
  );

  assign busy_o = run_q;
  assign addr_o = cmd_q.addr;
  assign cs_no  = stb_n[int'(STB_CS)];
  assign adv_no = stb_n[int'(STB_ADV)];
  assign oe_no  = stb_n[int'(STB_OE)];
  assign we_no  = stb_n[int'(STB_WE)];
endmodule

// File: rtl/ebs_seq_chk.sv
module ebs_seq_chk #(
  parameter int BW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          done_o,
  input logic          cs_no,
  input logic          adv_no,
  input logic          oe_no,
  input logic          we_no,
  input logic          ad_oe_o,
  input logic [BW-1:0] addr_o,
  input logic [BW-1:0] rdata_o
);
  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (cs_no && adv_no && oe_no && we_no && !ad_oe_o));

  // R5
  oe_we_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!oe_no && !we_no));

  // R2
  done_in_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);

  // R2
  done_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

  // R3
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> $stable(addr_o));

  // R6
  rdata_idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(rdata_o));
endmodule

bind ext_bus_seq ebs_seq_chk #(.BW(BW)) i_ebs_seq_chk (.*);

// File: tb/test_ext_bus_seq.sv
`timescale 1ns/1ps
module test_ext_bus_seq;
  localparam int TW = 6;
  localparam int BW = 16;

  typedef struct packed {
    logic wr; logic mux;
    logic [5:0] cs_on, cs_wr_off, adv_on, adv_rd_off, adv_wr_off, oe_on,
                access, we_on, we_off, data_on, rd_len, wr_len;
  } vec_t;

  // wr mux cs_on cs_wr_off adv_on adv_rd_off adv_wr_off oe_on access we_on we_off data_on rd_len wr_len
  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,6'd1,6'd0,6'd1,6'd3,6'd0,6'd3,6'd6,6'd0,6'd0,6'd0,6'd9,6'd0},
    '{1'b1,1'b0,6'd0,6'd8,6'd0,6'd0,6'd2,6'd0,6'd0,6'd2,6'd6,6'd0,6'd0,6'd10},
    '{1'b0,1'b1,6'd0,6'd0,6'd0,6'd3,6'd0,6'd4,6'd7,6'd0,6'd0,6'd0,6'd10,6'd0},
    '{1'b1,1'b1,6'd0,6'd9,6'd1,6'd0,6'd4,6'd0,6'd0,6'd4,6'd7,6'd4,6'd0,6'd11},
    '{1'b0,1'b0,6'd0,6'd0,6'd2,6'd2,6'd0,6'd5,6'd3,6'd0,6'd0,6'd0,6'd6,6'd0},
    '{1'b1,1'b1,6'd1,6'd6,6'd0,6'd0,6'd2,6'd0,6'd0,6'd5,6'd6,6'd5,6'd0,6'd8},
    '{1'b1,1'b0,6'd0,6'd1,6'd0,6'd0,6'd0,6'd0,6'd0,6'd0,6'd1,6'd0,6'd0,6'd0},
    '{1'b0,1'b1,6'd0,6'd0,6'd0,6'd1,6'd0,6'd0,6'd0,6'd0,6'd0,6'd0,6'd2,6'd0},
    '{1'b0,1'b0,6'd5,6'd0,6'd0,6'd0,6'd0,6'd0,6'd2,6'd0,6'd0,6'd0,6'd4,6'd0}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0, wr_i = 1'b0, mux_i = 1'b0;
  logic [BW-1:0] addr_i = '0, wdata_i = '0, ad_i = '0;
  logic [TW-1:0] cs_on_i = '0, cs_wr_off_i = '0, adv_on_i = '0, adv_rd_off_i = '0,
                 adv_wr_off_i = '0, oe_on_i = '0, access_i = '0, we_on_i = '0,
                 we_off_i = '0, data_on_i = '0, rd_len_i = '0, wr_len_i = '0;
  logic          busy_o, done_o, cs_no, adv_no, oe_no, we_no, ad_oe_o;
  logic [BW-1:0] addr_o, ad_o, rdata_o;

  int checks = 0;
  int failures = 0;
  logic [BW-1:0] last_rd = '0;

  always #10 clk_i = ~clk_i;

  ext_bus_seq #(.TW(TW), .BW(BW)) i_ext_bus_seq (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(req, "cs_n idle", int'(cs_no), 1);
    chk(req, "adv_n idle", int'(adv_no), 1);
    chk(req, "oe_n idle", int'(oe_no), 1);
    chk(req, "we_n idle", int'(we_no), 1);
    chk(req, "ad_oe idle", int'(ad_oe_o), 0);
    chk(req, "done idle", int'(done_o), 0);
    chk(req, "busy idle", int'(busy_o), 0);
  endtask

  task automatic load(input vec_t v, input int i);
    wr_i = v.wr; mux_i = v.mux;
    addr_i = 16'h1000 + 16'(i); wdata_i = 16'h5A00 + 16'(i);
    cs_on_i = v.cs_on; cs_wr_off_i = v.cs_wr_off; adv_on_i = v.adv_on;
    adv_rd_off_i = v.adv_rd_off; adv_wr_off_i = v.adv_wr_off; oe_on_i = v.oe_on;
    access_i = v.access; we_on_i = v.we_on; we_off_i = v.we_off;
    data_on_i = v.data_on; rd_len_i = v.rd_len; wr_len_i = v.wr_len;
  endtask

  function automatic logic [BW-1:0] bus_val(input int i, input int k);
    return 16'hC000 | 16'(i << 8) | 16'(k);
  endfunction

  task automatic run_vec(input int i);
    vec_t v;
    int len, cs_off, adv_off, ntk;
    logic [BW-1:0] a, w;
    v = VECS[i];
    a = 16'h1000 + 16'(i);
    w = 16'h5A00 + 16'(i);
    len = v.wr ? int'(v.wr_len) : int'(v.rd_len);
    if (len == 0) len = 1;
    cs_off  = v.wr ? int'(v.cs_wr_off) : int'(v.access) + 1;
    adv_off = v.wr ? int'(v.adv_wr_off) : int'(v.adv_rd_off);
    load(v, i);
    req_i = 1'b1;
    @(negedge clk_i);
    ntk = 0;
    for (int k = 0; k < 64; k++) begin
      bit e_cs, e_adv, e_oe, e_we, e_bus;
      logic [BW-1:0] e_val;
      if (!busy_o) break;
      ntk++;
      e_cs  = (k >= int'(v.cs_on)) && (k < cs_off);
      e_adv = (k >= int'(v.adv_on)) && (k < adv_off);
      e_oe  = !v.wr && (k >= int'(v.oe_on)) && (k <= int'(v.access));
      e_we  = v.wr && (k >= int'(v.we_on)) && (k < int'(v.we_off));
      e_val = '0;
      if (!v.mux) begin
        e_bus = v.wr; e_val = w;
      end else if (v.wr && k >= int'(v.data_on)) begin
        e_bus = 1'b1; e_val = w;
      end else if (k < adv_off) begin
        e_bus = 1'b1; e_val = a;
      end else begin
        e_bus = 1'b0;
      end
      chk("R4", $sformatf("v%0d t%0d cs", i, k), int'(!cs_no), int'(e_cs));
      chk("R4", $sformatf("v%0d t%0d adv", i, k), int'(!adv_no), int'(e_adv));
      chk("R5", $sformatf("v%0d t%0d oe", i, k), int'(!oe_no), int'(e_oe));
      chk("R5", $sformatf("v%0d t%0d we", i, k), int'(!we_no), int'(e_we));
      chk(v.mux ? "R8" : "R7", $sformatf("v%0d t%0d ad_oe", i, k), int'(ad_oe_o), int'(e_bus));
      if (e_bus)
        chk(v.mux ? "R8" : "R7", $sformatf("v%0d t%0d ad", i, k), int'(ad_o), int'(e_val));
      chk("R3", $sformatf("v%0d t%0d addr", i, k), int'(addr_o), int'(a));
      chk("R2", $sformatf("v%0d t%0d done", i, k), int'(done_o), int'(k == len - 1));
      // conflicting request while busy; dropped before the final edge
      req_i   = (k != len - 1);
      addr_i  = 16'hDEAD;
      wdata_i = 16'hBEEF;
      wr_i    = ~v.wr;
      ad_i    = bus_val(i, k);
      @(negedge clk_i);
    end
    req_i = 1'b0;
    chk("R2", $sformatf("v%0d length", i), ntk, len);
    chk_idle("R9");
    if (!v.wr) last_rd = bus_val(i, int'(v.access));
    chk("R6", $sformatf("v%0d rdata", i), int'(rdata_o), int'(last_rd));
    @(negedge clk_i);
    chk("R3", $sformatf("v%0d no restart", i), int'(busy_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk_idle("R1");
    chk("R1", "rdata reset", int'(rdata_o), 0);
    chk("R1", "addr reset", int'(addr_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_idle("R9");

    for (int i = 0; i < NV; i++) run_vec(i);

    // back-to-back: request held high starts next access after one idle tick
    load(VECS[0], 0);
    req_i = 1'b1;
    @(negedge clk_i);
    chk("R2", "b2b start", int'(busy_o), 1);
    repeat (8) @(negedge clk_i);
    chk("R2", "b2b last tick done", int'(done_o), 1);
    @(negedge clk_i);
    chk("R2", "b2b idle gap", int'(busy_o), 0);
    @(negedge clk_i);
    chk("R2", "b2b restart", int'(busy_o), 1);
    req_i = 1'b0;
    repeat (2) @(negedge clk_i);

    // reset mid-access
    rst_ni = 1'b0;
    #1;
    chk_idle("R1");
    chk("R1", "rdata mid reset", int'(rdata_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_idle("R1");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    failures++;
    $display("FAIL R2 watchdog: actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule